// File: doc/BRIEF.md
# Reservation Monitor for Linked Load and Conditional Store

This block sits beside a shared memory and lets several requesters build atomic read-modify-write sequences, such as taking a lock where 0 means free and 1 means held. Each requester lane can present one access per cycle.

A linked load reads like a plain load and also leaves a reservation on the word it touched. A later conditional store from the same lane is allowed to write only if nothing else has written that word in the meantime. The block grants or refuses each write through a per-lane permit signal, which is combinational in the same cycle. One cycle later it returns a status word of 1 (the store took place) or 0 (it was refused), which goes into the requester's destination register.

Writes from agents outside the lanes, such as a DMA engine, arrive on a separate snoop port and also break reservations. Addresses are byte addresses. Matching is done on whole words, so the byte-select bits are ignored.

Top module: `llsc_monitor`

## Requirements
- R1: Reset leaves every lane without a reservation, so a conditional store issued straight after reset gets permit 0 and status 0.
- R2: A linked load followed by a conditional store from the same lane to the same word, with no write in between, gets permit 1 in the store's cycle. The status word is 1, and all bits above bit 0 of the status word are always 0.
- R3: `result_valid` of a lane pulses for exactly the one cycle after that lane issues a conditional store (op code 3), with the status in `result_word` in that same cycle. Op codes 0 (load), 1 (store) and 2 (linked load) produce no status.
- R4: Every conditional store clears its own lane's reservation, whether it succeeds or fails. A second conditional store without a new linked load therefore fails.
- R5: A conditional store to a word other than the reserved word fails. Addresses that differ only in the byte-select bits (the low log2(DW/8) bits) count as the same word.
- R6: A new linked load replaces the lane's earlier reservation.
- R7: A plain store from another lane to the reserved word clears the reservation. A plain store from the owning lane does not clear it.
- R8: A snoop write to the reserved word clears the reservation. A snoop write to a different word leaves it intact.
- R9: A successful conditional store from another lane to the reserved word clears the reservation. A failed conditional store from another lane does not clear it.
- R10: When several lanes issue conditional stores to the same word in one cycle, each holding a valid reservation for it, only the lowest-numbered lane succeeds (with LOW_FIRST=1). The others fail.
- R11: A conditional store fails when, in the same cycle, another lane's plain store or a snoop write targets the same word. That competing write is still permitted.
- R12: A linked load that coincides with any other write to the same word does not establish a reservation.
- R13: Plain stores always get permit 1. Loads and linked loads never get permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_valid | input | NREQ | Per-lane access request |
| lane_op | input | 2*NREQ | Per-lane op: 0 load, 1 store, 2 linked load, 3 conditional store |
| lane_addr | input | AW*NREQ | Per-lane byte address |
| ext_wr_valid | input | 1 | Snoop: a write by an agent outside the lanes |
| ext_wr_addr | input | AW | Snoop write byte address |
| wr_permit | output | NREQ | Per-lane permission for memory to perform the write this cycle |
| result_valid | output | NREQ | Per-lane status strobe, one cycle after a conditional store |
| result_word | output | DW*NREQ | Per-lane status word, 1 on success and 0 on failure |

## Verification
The collisions of interest are a conditional store meeting a competing write to the same word in the same cycle. The competing write can be another lane's conditional store, another lane's plain store or a snoop write. A linked load meeting a write to its word in the same cycle is the second collision of interest.

The bench provokes each collision by driving both lanes, or a lane and the snoop port, before one clock edge. It judges the same-cycle permit pattern first. It then judges the status word one cycle later, and finally judges whether the reservation survived, using a follow-up conditional store on the lane that owns it.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_LINK  = 2'd2,
      OP_COND  = 2'd3
   } mem_op_e;

endpackage

// File: rtl/llsc_rsv_slot.sv
module llsc_rsv_slot #(
   parameter int NREQ = 4,
   parameter int WAW  = 30,
   parameter int SELF = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 link_set,
   input  logic                 cond_seen,
   input  logic [WAW-1:0]       own_waddr,
   input  logic [NREQ-1:0]      st_en,
   input  logic [NREQ-1:0]      sc_en,
   input  logic [NREQ*WAW-1:0]  lane_waddr,
   input  logic                 ext_en,
   input  logic [WAW-1:0]       ext_waddr,
   output logic                 rsv_v,
   output logic [WAW-1:0]       rsv_waddr,
   output logic                 plain_hit
);

   function automatic logic foreign_hit(input logic [NREQ-1:0]     en,
                                        input logic [NREQ*WAW-1:0] addrs,
                                        input logic [WAW-1:0]      cmp);
      logic h;
      h = 1'b0;
      for (int j = 0; j < NREQ; j++) begin
         if (j != SELF && en[j] && addrs[j*WAW +: WAW] == cmp) h = 1'b1;
      end
      return h;
   endfunction

   logic hit_rsv_plain;
   logic hit_rsv_cond;
   logic hit_new_any;

   always_comb begin
      hit_rsv_plain = foreign_hit(st_en, lane_waddr, rsv_waddr) |
                      (ext_en && ext_waddr == rsv_waddr);
      hit_rsv_cond  = foreign_hit(sc_en, lane_waddr, rsv_waddr);
      hit_new_any   = foreign_hit(st_en, lane_waddr, own_waddr) |
                      foreign_hit(sc_en, lane_waddr, own_waddr) |
                      (ext_en && ext_waddr == own_waddr);
   end

   assign plain_hit = hit_rsv_plain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsv_v     <= 1'b0;
         rsv_waddr <= '0;
      end else if (link_set) begin
         rsv_v     <= !hit_new_any;
         rsv_waddr <= own_waddr;
      end else if (cond_seen) begin
         rsv_v     <= 1'b0;
      end else if (hit_rsv_plain || hit_rsv_cond) begin
         rsv_v     <= 1'b0;
      end
   end

   // R8
   snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_en && rsv_v && ext_waddr == rsv_waddr && !link_set) |=> !rsv_v);

   // R12
   link_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_set && ext_en && ext_waddr == own_waddr) |=> !rsv_v);

endmodule

// File: rtl/llsc_cond_arb.sv
module llsc_cond_arb #(
   parameter int NREQ      = 4,
   parameter int WAW       = 30,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [NREQ-1:0]     cand,
   input  logic [NREQ*WAW-1:0] waddr,
   output logic [NREQ-1:0]     win
);

   for (genvar g = 0; g < NREQ; g++) begin : g_lane
      logic blocked;
      if (LOW_FIRST) begin : g_low
         always_comb begin
            blocked = 1'b0;
            for (int k = 0; k < g; k++) begin
               if (cand[k] && waddr[k*WAW +: WAW] == waddr[g*WAW +: WAW]) blocked = 1'b1;
            end
         end
      end else begin : g_high
         always_comb begin
            blocked = 1'b0;
            for (int k = g + 1; k < NREQ; k++) begin
               if (cand[k] && waddr[k*WAW +: WAW] == waddr[g*WAW +: WAW]) blocked = 1'b1;
            end
         end
      end
      assign win[g] = cand[g] && !blocked;
   end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
   parameter int NREQ      = 4,
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NREQ-1:0]      lane_valid,
   input  logic [2*NREQ-1:0]    lane_op,
   input  logic [AW*NREQ-1:0]   lane_addr,
   input  logic                 ext_wr_valid,
   input  logic [AW-1:0]        ext_wr_addr,
   output logic [NREQ-1:0]      wr_permit,
   output logic [NREQ-1:0]      result_valid,
   output logic [DW*NREQ-1:0]   result_word
);
   import llsc_pkg::*;

   localparam int OFS = $clog2(DW / 8);
   localparam int WAW = AW - OFS;

   if (NREQ < 1) begin : g_bad_nreq
      $error("llsc_monitor: NREQ must be at least 1");
   end
   if (DW < 8 || (DW % 8) != 0 || (1 << OFS) != DW / 8) begin : g_bad_dw
      $error("llsc_monitor: DW must be a power-of-two number of bytes");
   end
   if (WAW < 1) begin : g_bad_aw
      $error("llsc_monitor: AW too small for DW");
   end

   logic [NREQ-1:0]     is_st, is_ll, is_sc;
   logic [NREQ-1:0]     rsv_v, plain_hit, cand, win;
   logic [NREQ*WAW-1:0] lane_waddr, rsv_waddr_all;
   logic [WAW-1:0]      ext_waddr;

   assign ext_waddr = ext_wr_addr[AW-1:OFS];

   if (OFS > 0) begin : g_ext_lsb
      logic unused_ext_lsb;
      assign unused_ext_lsb = ^ext_wr_addr[OFS-1:0];
   end

   for (genvar g = 0; g < NREQ; g++) begin : g_lane
      mem_op_e op_g;
      assign op_g  = mem_op_e'(lane_op[2*g +: 2]);
      assign is_st[g] = lane_valid[g] && op_g == OP_STORE;
      assign is_ll[g] = lane_valid[g] && op_g == OP_LINK;
      assign is_sc[g] = lane_valid[g] && op_g == OP_COND;
      assign lane_waddr[g*WAW +: WAW] = lane_addr[g*AW + OFS +: WAW];

      if (OFS > 0) begin : g_lsb
         logic unused_lane_lsb;
         assign unused_lane_lsb = ^lane_addr[g*AW +: OFS];
      end

      llsc_rsv_slot #(.NREQ(NREQ), .WAW(WAW), .SELF(g)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .link_set   (is_ll[g]),
         .cond_seen  (is_sc[g]),
         .own_waddr  (lane_waddr[g*WAW +: WAW]),
         .st_en      (is_st),
         .sc_en      (win),
         .lane_waddr (lane_waddr),
         .ext_en     (ext_wr_valid),
         .ext_waddr  (ext_waddr),
         .rsv_v      (rsv_v[g]),
         .rsv_waddr  (rsv_waddr_all[g*WAW +: WAW]),
         .plain_hit  (plain_hit[g])
      );

      assign cand[g] = is_sc[g] && rsv_v[g] && !plain_hit[g] &&
                       rsv_waddr_all[g*WAW +: WAW] == lane_waddr[g*WAW +: WAW];

      assign wr_permit[g] = is_st[g] | win[g];

      logic          res_v_q;
      logic [DW-1:0] res_w_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_v_q <= 1'b0;
            res_w_q <= '0;
         end else begin
            res_v_q <= is_sc[g];
            res_w_q <= {{(DW-1){1'b0}}, win[g]};
         end
      end
      assign result_valid[g]          = res_v_q;
      assign result_word[g*DW +: DW]  = res_w_q;

      // R1
      reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> !rsv_v[g]);

      // R4
      cond_clears_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
         is_sc[g] |=> !rsv_v[g]);

      // R2
      status_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
         result_valid[g] |-> result_word[g*DW + 1 +: DW-1] == '0);

      // R13
      permit_needs_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (lane_valid[g] && lane_op[2*g +: 2] != 2'd1 && wr_permit[g]) |->
         (lane_op[2*g +: 2] == 2'd3 && rsv_v[g]));
   end

   llsc_cond_arb #(.NREQ(NREQ), .WAW(WAW), .LOW_FIRST(LOW_FIRST)) u_arb (
      .cand  (cand),
      .waddr (lane_waddr),
      .win   (win)
   );

   for (genvar a = 0; a < NREQ; a++) begin : g_pa
      for (genvar b = a + 1; b < NREQ; b++) begin : g_pb
         // R10
         single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (win[a] && win[b]) |-> lane_waddr[a*WAW +: WAW] != lane_waddr[b*WAW +: WAW]);
      end
   end

endmodule

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
   localparam int NREQ = 4;
   localparam int AW   = 32;
   localparam int DW   = 32;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NREQ-1:0]     lane_valid = '0;
   logic [2*NREQ-1:0]   lane_op = '0;
   logic [AW*NREQ-1:0]  lane_addr = '0;
   logic                ext_wr_valid = 1'b0;
   logic [AW-1:0]       ext_wr_addr = '0;
   logic [NREQ-1:0]     wr_permit;
   logic [NREQ-1:0]     result_valid;
   logic [DW*NREQ-1:0]  result_word;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   llsc_monitor #(.NREQ(NREQ), .AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_op(lane_op),
      .lane_addr(lane_addr), .ext_wr_valid(ext_wr_valid), .ext_wr_addr(ext_wr_addr),
      .wr_permit(wr_permit), .result_valid(result_valid), .result_word(result_word));

   task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic idle();
      lane_valid   = '0;
      lane_op      = '0;
      lane_addr    = '0;
      ext_wr_valid = 1'b0;
      ext_wr_addr  = '0;
   endtask

   task automatic put(int l, logic [1:0] op, logic [31:0] a);
      lane_valid[l]       = 1'b1;
      lane_op[l*2 +: 2]   = op;
      lane_addr[l*AW +: AW] = a;
   endtask

   task automatic clock();
      @(posedge clk);
      #2;
   endtask

   task automatic run_op(int l, logic [1:0] op, logic [31:0] a);
      idle();
      put(l, op, a);
      clock();
      idle();
   endtask

   task automatic run_sc(int l, logic [31:0] a, logic exp, string rq);
      idle();
      put(l, 2'd3, a);
      #1;
      chk(rq, "permit", 32'(wr_permit[l]), 32'(exp));
      clock();
      idle();
      chk(rq, "result_valid", 32'(result_valid[l]), 32'd1);
      chk(rq, "status", result_word[l*DW +: DW], 32'(exp));
   endtask

   task automatic t_reset();
      chk("R1", "permit idle", 32'(wr_permit), 32'd0);
      chk("R3", "no status idle", 32'(result_valid), 32'd0);
      run_sc(0, 32'h40, 1'b0, "R1");
   endtask

   task automatic t_basic();
      idle();
      put(1, 2'd2, 32'h100);
      put(2, 2'd0, 32'h100);
      #1;
      chk("R13", "link/load permit", 32'(wr_permit), 32'd0);
      clock();
      idle();
      chk("R3", "no status after link/load", 32'(result_valid), 32'd0);
      run_sc(1, 32'h100, 1'b1, "R2");
      clock();
      chk("R3", "status one cycle only", 32'(result_valid), 32'd0);
      run_sc(1, 32'h100, 1'b0, "R4");
   endtask

   task automatic t_word_match();
      run_op(0, 2'd2, 32'h200);
      run_sc(0, 32'h204, 1'b0, "R5");
      run_sc(0, 32'h200, 1'b0, "R4");
      run_op(0, 2'd2, 32'h300);
      run_sc(0, 32'h302, 1'b1, "R5");
   endtask

   task automatic t_replace();
      run_op(2, 2'd2, 32'h400);
      run_op(2, 2'd2, 32'h500);
      run_sc(2, 32'h400, 1'b0, "R6");
      run_op(2, 2'd2, 32'h400);
      run_op(2, 2'd2, 32'h500);
      run_sc(2, 32'h500, 1'b1, "R6");
   endtask

   task automatic t_store();
      run_op(2, 2'd2, 32'h600);
      idle();
      put(3, 2'd1, 32'h601);
      #1;
      chk("R13", "store permit", 32'(wr_permit[3]), 32'd1);
      clock();
      idle();
      run_sc(2, 32'h600, 1'b0, "R7");
      run_op(2, 2'd2, 32'h600);
      run_op(2, 2'd1, 32'h600);
      run_sc(2, 32'h600, 1'b1, "R7");
   endtask

   task automatic t_ext();
      run_op(0, 2'd2, 32'h700);
      idle(); ext_wr_valid = 1'b1; ext_wr_addr = 32'h704; clock(); idle();
      run_sc(0, 32'h700, 1'b1, "R8");
      run_op(0, 2'd2, 32'h700);
      idle(); ext_wr_valid = 1'b1; ext_wr_addr = 32'h703; clock(); idle();
      run_sc(0, 32'h700, 1'b0, "R8");
   endtask

   task automatic t_sc_other();
      run_op(0, 2'd2, 32'h800);
      run_op(1, 2'd2, 32'h800);
      run_sc(1, 32'h800, 1'b1, "R9");
      run_sc(0, 32'h800, 1'b0, "R9");
      run_op(0, 2'd2, 32'h900);
      run_sc(1, 32'h900, 1'b0, "R9");
      run_sc(0, 32'h900, 1'b1, "R9");
   endtask

   task automatic t_dual_sc();
      idle();
      put(1, 2'd2, 32'hA00);
      put(3, 2'd2, 32'hA00);
      clock();
      idle();
      put(1, 2'd3, 32'hA00);
      put(3, 2'd3, 32'hA00);
      #1;
      chk("R10", "low lane permit", 32'(wr_permit[1]), 32'd1);
      chk("R10", "high lane permit", 32'(wr_permit[3]), 32'd0);
      clock();
      idle();
      chk("R10", "low lane status", result_word[1*DW +: DW], 32'd1);
      chk("R10", "high lane status", result_word[3*DW +: DW], 32'd0);
      chk("R3", "both status strobes", 32'(result_valid), 32'b1010);
   endtask

   task automatic t_sc_vs_write();
      run_op(0, 2'd2, 32'hB00);
      idle();
      put(0, 2'd3, 32'hB00);
      put(2, 2'd1, 32'hB00);
      #1;
      chk("R11", "sc permit vs store", 32'(wr_permit[0]), 32'd0);
      chk("R11", "store permit", 32'(wr_permit[2]), 32'd1);
      clock();
      idle();
      chk("R11", "sc status vs store", result_word[0 +: DW], 32'd0);
      run_op(0, 2'd2, 32'hB00);
      idle();
      put(0, 2'd3, 32'hB00);
      ext_wr_valid = 1'b1; ext_wr_addr = 32'hB02;
      #1;
      chk("R11", "sc permit vs snoop", 32'(wr_permit[0]), 32'd0);
      clock();
      idle();
      chk("R11", "sc status vs snoop", result_word[0 +: DW], 32'd0);
   endtask

   task automatic t_link_race();
      idle();
      put(1, 2'd2, 32'hC00);
      ext_wr_valid = 1'b1; ext_wr_addr = 32'hC00;
      clock();
      idle();
      run_sc(1, 32'hC00, 1'b0, "R12");
      idle();
      put(1, 2'd2, 32'hC00);
      put(2, 2'd1, 32'hC04);
      clock();
      idle();
      run_sc(1, 32'hC00, 1'b1, "R12");
   endtask

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      clock();
      t_reset();
      t_basic();
      t_word_match();
      t_replace();
      t_store();
      t_ext();
      t_sc_other();
      t_dual_sc();
      t_sc_vs_write();
      t_link_race();
      clock();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL all-requirements watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule